// File: doc/BRIEF.md
# Idle-Locking Stream Descrambler

This block sits on the receive side of a 100 Mb/s twisted-pair style PHY and turns a scrambled serial bit stream back into plain bits. Each clock it can take zero, one or two scrambled bits, and each bit comes with its own valid flag. It recovers the far end's keystream with an 11-stage shift register. While the line carries idle, which is a plain value of all ones, the register copies the far end's state straight from the received bits.

A run counter measures how many received bits in a row descramble to one. When that run reaches 32 the block declares lock. From then on the register runs on its own feedback and the block passes descrambled bits out with per-bit valid flags, one cycle later.

While locked, an idle run of 29 bits or more has to keep appearing. If none appears within a hold window, lock is dropped. A signal-status input that goes low for a single cycle also drops lock at once. A test-mode input replaces the long hold window with a short one.

Top module: `idle_lock_descrambler`

## Requirements
- R1: After reset, `locked` is 0 and `plain_vld` and `plain_bits` are all zero.
- R2: The keystream bit is the XOR of register stages 8 and 10, counted from 0. While locked, the new register bit is that keystream bit, and each plain bit equals the received bit XOR the keystream bit.
- R3: When two bits arrive in one cycle, lane 0 is handled before lane 1, and the register shifts once per valid bit. A far-end scrambler that handles bit 0 first therefore round-trips correctly.
- R4: While unlocked, the register shifts in the inverted received bit. A descrambled value of 1 extends the run counter, and a descrambled value of 0 clears it.
- R5: `locked` rises when the run counter reaches 32, and never after fewer than 32 valid bits since the run began. Starting from an empty run, 16 cycles of two idle bits each give lock.
- R6: `plain_vld[i]` in cycle t+1 equals `scr_vld[i]` in cycle t, ANDed with `locked` and `sig_ok` in cycle t. A plain bit whose valid is 0 reads 0.
- R7: If `sig_ok` is low for one cycle, `locked` is 0 in the next cycle, the run is cleared, and the inputs of that cycle are ignored.
- R8: While locked, a run of 29 or more refreshes the hold window. If the window elapses without a refresh, lock drops: in test mode the block is unlocked after exactly 64 cycles without a refresh.
- R9: With `test_mode` low the window is `HOLD_NORM` cycles (90250 by default), so 100 cycles without idle keep lock. Raising `test_mode` after a longer gap drops lock at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_ok | input | 1 | Line signal present; low forces resynchronization |
| test_mode | input | 1 | Selects the short hold window |
| scr_bits | input | 2 | Scrambled bits, lane 0 first |
| scr_vld | input | 2 | Valid flag per scrambled bit |
| plain_bits | output | 2 | Descrambled bits |
| plain_vld | output | 2 | Valid flag per descrambled bit |
| locked | output | 1 | Keystream synchronized |

## Verification
The bench drives a model of the far-end scrambler that handles lane 0 first. It walks all four valid patterns, so a design that swapped lane order or shifted on invalid bits would send back wrong plain bits. Lock timing is checked at the exact edge: not after 31 bits, set after 43 from a cold register, and set after exactly 16 double-bit cycles from an empty run. This catches an off-by-one threshold or a run counter that fails to clear. The hold timeout is checked at cycle 63 versus 64, and the test-mode switch after a long gap is checked as well. A timer that missed the shorter limit would keep lock forever, and a single low `sig_ok` cycle that failed to unlock would be reported.

// File: rtl/dscr_pkg.sv
package dscr_pkg;
  localparam int LFSR_W   = 11;
  localparam int TAP_A    = 8;
  localparam int TAP_B    = 10;
  localparam int RUN_W    = 6;
  localparam int LOCK_RUN = 32;
  localparam int IDLE_RUN = 29;

  typedef logic [LFSR_W-1:0] lfsr_t;
  typedef logic [RUN_W-1:0]  run_t;

  function automatic logic keystream(input lfsr_t s);
    return s[TAP_A] ^ s[TAP_B];
  endfunction
endpackage

// File: rtl/dscr_lane.sv
module dscr_lane
  import dscr_pkg::*;
(
  input  lfsr_t lfsr_i,
  input  run_t  run_i,
  input  logic  bit_i,
  input  logic  vld_i,
  input  logic  locked_i,
  output lfsr_t lfsr_o,
  output run_t  run_o,
  output logic  plain_o
);
  logic ks;
  logic fb;

  always_comb begin
    ks      = keystream(lfsr_i);
    plain_o = bit_i ^ ks;
    fb      = locked_i ? ks : ~bit_i;
    lfsr_o  = lfsr_i;
    run_o   = run_i;
    if (vld_i) begin
      lfsr_o = {lfsr_i[LFSR_W-2:0], fb};
      if (!plain_o)
        run_o = '0;
      else if (run_i < run_t'(LOCK_RUN))
        run_o = run_i + run_t'(1);
    end
  end
endmodule

// File: rtl/dscr_hold.sv
module dscr_hold #(
  parameter int HOLD_NORM = 90250,
  parameter int HOLD_TEST = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic refresh,
  input  logic test_mode,
  output logic expire
);
  localparam int CW = $clog2(HOLD_NORM + 1);

  logic [CW-1:0] cnt_q, cnt_n, lim;

  always_comb begin
    lim    = test_mode ? CW'(HOLD_TEST - 1) : CW'(HOLD_NORM - 1);
    expire = run_en && !refresh && (cnt_q >= lim);
    if (!run_en || refresh || expire)
      cnt_n = '0;
    else
      cnt_n = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/idle_lock_descrambler.sv
module idle_lock_descrambler
  import dscr_pkg::*;
#(
  parameter int LANES     = 2,
  parameter int HOLD_NORM = 90250,
  parameter int HOLD_TEST = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_ok,
  input  logic             test_mode,
  input  logic [LANES-1:0] scr_bits,
  input  logic [LANES-1:0] scr_vld,
  output logic [LANES-1:0] plain_bits,
  output logic [LANES-1:0] plain_vld,
  output logic             locked
);
  lfsr_t lfsr_q;
  run_t  run_q, run_n;
  logic  lock_q, lock_n;
  logic  expire, refresh;
  logic [LANES-1:0] plain_c, vld_g;
  logic [LANES-1:0] obits_q, obits_n, ovld_q, ovld_n;
  lfsr_t lfsr_c [LANES+1];
  run_t  run_c  [LANES+1];

  assign vld_g      = scr_vld & {LANES{sig_ok}};
  assign lfsr_c[0]  = lfsr_q;
  assign run_c[0]   = run_q;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      dscr_lane u_lane (
        .lfsr_i   (lfsr_c[g]),
        .run_i    (run_c[g]),
        .bit_i    (scr_bits[g]),
        .vld_i    (vld_g[g]),
        .locked_i (lock_q),
        .lfsr_o   (lfsr_c[g+1]),
        .run_o    (run_c[g+1]),
        .plain_o  (plain_c[g])
      );
    end
  endgenerate

  assign refresh = run_c[LANES] >= run_t'(IDLE_RUN);

  dscr_hold #(.HOLD_NORM(HOLD_NORM), .HOLD_TEST(HOLD_TEST)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (lock_q && sig_ok),
    .refresh   (refresh),
    .test_mode (test_mode),
    .expire    (expire)
  );

  always_comb begin
    lock_n  = sig_ok && !expire &&
              (lock_q || (run_c[LANES] >= run_t'(LOCK_RUN)));
    run_n   = (!sig_ok || expire) ? '0 : run_c[LANES];
    ovld_n  = vld_g & {LANES{lock_q}};
    obits_n = plain_c & ovld_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q  <= '0;
      run_q   <= '0;
      lock_q  <= 1'b0;
      ovld_q  <= '0;
      obits_q <= '0;
    end else begin
      lfsr_q  <= lfsr_c[LANES];
      run_q   <= run_n;
      lock_q  <= lock_n;
      ovld_q  <= ovld_n;
      obits_q <= obits_n;
    end
  end

  assign locked     = lock_q;
  assign plain_vld  = ovld_q;
  assign plain_bits = obits_q;
endmodule

// File: rtl/idle_lock_descrambler_chk.sv
module idle_lock_descrambler_chk
  import dscr_pkg::*;
#(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sig_ok,
  input logic [LANES-1:0] scr_vld,
  input logic [LANES-1:0] plain_vld,
  input logic             locked,
  input run_t             run_q,
  input logic             expire
);
  a_r6_vld_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> plain_vld == '0);

  a_r6_vld_subset: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (plain_vld & ~$past(scr_vld)) == '0);

  a_r7_sig_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_ok |=> !locked);

  a_r5_lock_at_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> run_q == run_t'(LOCK_RUN));

  a_r8_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(locked) && $past(sig_ok)) |-> $past(expire));
endmodule

bind idle_lock_descrambler idle_lock_descrambler_chk #(.LANES(LANES)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sig_ok    (sig_ok),
  .scr_vld   (scr_vld),
  .plain_vld (plain_vld),
  .locked    (locked),
  .run_q     (run_q),
  .expire    (expire)
);

// File: tb/test_idle_lock_descrambler.sv
module test_idle_lock_descrambler;
  localparam int CLK_PERIOD = 8;

  logic       clk = 1'b0;
  logic       rst_n, sig_ok, test_mode;
  logic [1:0] scr_bits, scr_vld, plain_bits, plain_vld;
  logic       locked;
  logic [10:0] rem;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idle_lock_descrambler i_idle_lock_descrambler (
    .clk(clk), .rst_n(rst_n), .sig_ok(sig_ok), .test_mode(test_mode),
    .scr_bits(scr_bits), .scr_vld(scr_vld),
    .plain_bits(plain_bits), .plain_vld(plain_vld), .locked(locked)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One cycle: far-end scrambler handles lane 0 first; outputs checked next negedge
  task automatic step(input logic [1:0] v, input logic [1:0] p);
    logic [1:0] s;
    logic lk, ks, sg;
    for (int i = 0; i < 2; i++) begin
      if (v[i]) begin
        ks   = rem[8] ^ rem[10];
        s[i] = p[i] ^ ks;
        rem  = {rem[9:0], ks};
      end else begin
        s[i] = 1'($urandom);
      end
    end
    lk = locked;
    sg = sig_ok;
    scr_bits = s;
    scr_vld  = v;
    @(negedge clk);
    check("R6 valid", {6'd0, plain_vld}, {6'd0, v & {2{lk & sg}}});
    check("R2/R3 data", {6'd0, plain_bits}, {6'd0, p & v & {2{lk & sg}}});
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rem = 11'h5a3;
    rst_n = 1'b0; sig_ok = 1'b1; test_mode = 1'b1;
    scr_bits = '0; scr_vld = '0;
    repeat (3) @(negedge clk);
    check("R1 locked", {7'd0, locked}, 8'd0);
    check("R1 vld", {6'd0, plain_vld}, 8'd0);
    check("R1 bits", {6'd0, plain_bits}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4/R5: cold sync, one idle bit per cycle
    repeat (31) step(2'b01, 2'b01);
    check("R5 no lock after 31", {7'd0, locked}, 8'd0);
    repeat (12) step(2'b01, 2'b01);
    check("R5 lock after 43", {7'd0, locked}, 8'd1);

    // R2/R3/R6: all valid patterns with random data and idle refresh
    for (int r = 0; r < 6; r++) begin
      for (int c = 0; c < 16; c++) step(2'(c), 2'($urandom));
      repeat (16) step(2'b11, 2'b11);
    end

    // R8: hold timeout in test mode
    repeat (63) step(2'b11, 2'b00);
    check("R8 held at 63", {7'd0, locked}, 8'd1);
    step(2'b11, 2'b00);
    check("R8 dropped at 64", {7'd0, locked}, 8'd0);

    // R4/R5: relock from empty run, two bits per cycle
    repeat (15) step(2'b11, 2'b11);
    check("R5 no relock at 15", {7'd0, locked}, 8'd0);
    step(2'b11, 2'b11);
    check("R5 relock at 16", {7'd0, locked}, 8'd1);

    // R7: single low sig_ok cycle
    repeat (8) step(2'b11, 2'($urandom));
    sig_ok = 1'b0;
    step(2'b00, 2'b00);
    check("R7 unlocked after drop", {7'd0, locked}, 8'd0);
    sig_ok = 1'b1;
    repeat (15) step(2'b11, 2'b11);
    check("R7 run cleared, no lock at 15", {7'd0, locked}, 8'd0);
    step(2'b11, 2'b11);
    check("R7 relock at 16", {7'd0, locked}, 8'd1);

    // R9: normal window is long; test mode then drops at once
    test_mode = 1'b0;
    repeat (100) step(2'b11, 2'b00);
    check("R9 normal window holds", {7'd0, locked}, 8'd1);
    test_mode = 1'b1;
    step(2'b11, 2'b00);
    check("R9 test mode drops", {7'd0, locked}, 8'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule